// File: doc/BRIEF.md
# Edge-Latched Interrupt Control

This block is the per-source front end of an interrupt controller. It watches a single edge-sensitive request line. A rising edge is brought into the clock domain, detected once, and held in a capture latch until software clears it. A small control register sets three things: whether the source is enabled, the 3-bit priority level it presents, and a clear strobe. The block drives a level-coded request toward a downstream priority encoder. That request is the programmed level while the source is pending, enabled and at a nonzero level, and zero otherwise. A read of the same register returns the enable bit, the level and the live latch status.

The elaboration parameter `STRICT` picks the behaviour of the enable bit. With `STRICT = 0` (legacy), clearing the enable bit only gates the request, and the latch goes on recording edges. A later enable therefore raises the request at once. With `STRICT = 1`, a clear enable holds the latch in reset, so edges that arrive while the source is disabled are lost. In both variants, software that must mask the source without losing an edge can program level 0 and leave the enable bit set.

The latch is a three-state machine:
- DISARMED is entered only with `STRICT = 1`, while the enable bit is clear.
- ARMED means enabled and waiting for an edge.
- PENDING means an edge has been captured.

Transitions:
- ARMED to PENDING on a detected edge.
- PENDING to ARMED on a clear write that does not coincide with an edge.
- ARMED or PENDING to DISARMED when a write leaves the enable bit clear (strict only).
- DISARMED to ARMED, or directly to PENDING if an edge coincides, when a write sets the enable bit.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable bit is 0, the level is 0, the latch is clear, `irq_req` is 0 and `rd_data` is 0.
- R2: The request line passes through two synchronizer flops and a previous-value flop. When `src_i` rises before clock edge k, the latch status is visible after edge k+2 and not before. A line held high sets the latch only once, so after a clear it stays clear until the line falls and rises again.
- R3: `irq_req` equals the level field when the latch is set, the enable bit is 1 and the level is nonzero. In every other case it is 0.
- R4: With `STRICT = 0`, an edge that arrives while the enable bit is 0 is still latched and `irq_req` stays 0. A later write that sets the enable bit drives `irq_req` to the level in the cycle after that write.
- R5: With `STRICT = 1`, the latch is clear whenever the enable bit is 0. Edges that arrive while disabled are lost. A write that clears the enable bit also drops a pending latch at the same clock edge.
- R6: A level of 0 with the enable bit set forces `irq_req` to 0 while the latch still records edges in both variants. Writing a nonzero level afterwards raises the request.
- R7: A write with the clear bit set resets the latch. If a detected edge falls in the same cycle as that write, the edge wins and the latch stays set.
- R8: Register layout, the same for writes and reads: bit 0 is enable and bits 3:1 are the level. Bit 4 is the clear strobe on a write and the latch status on a read. Bits 7:5 read as 0. Every write updates both enable and level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 1 | Edge-sensitive interrupt request line, asynchronous |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | DATA_W (8) | Write data: enable, level, clear |
| rd_data | output | DATA_W (8) | Readback: enable, level, latch status |
| irq_req | output | LEVEL_W (3) | Level-coded request to the priority encoder, 0 = none |

## Verification
Two copies of the block, one per variant, get identical stimulus. The main stimulus is a full sweep over enable, all eight levels and latch-set versus latch-empty. Comparing the two copies' readback and request separates gating from capture: where the edge was latched with the enable bit low, only the legacy copy keeps it. Directed patterns cover several further cases:
- Edge latency, counted clock edge by clock edge.
- A line held high across a clear, to show single capture.
- A clear write that lands in the same cycle as a detected edge, and one that does not.
- Enabling after a disabled-time edge.
- A level-0 mask that is then lifted.

// File: rtl/irq_edge_pkg.sv
`timescale 1ns/1ps
package irq_edge_pkg;

    typedef enum logic [1:0] {
        LS_DISARMED = 2'd0,
        LS_ARMED    = 2'd1,
        LS_PENDING  = 2'd2
    } latch_state_e;

    localparam int CR_EN_BIT  = 0;
    localparam int CR_LVL_LSB = 1;

endpackage

// File: rtl/irq_edge_sync.sv
`timescale 1ns/1ps
module irq_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    output logic edge_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= src_i;
    end

    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[g] <= 1'b0;
            else        sync_q[g] <= sync_q[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[MSB];
    end

    always_comb edge_o = sync_q[MSB] & ~prev_q;

    // R2: one rising edge yields a single-cycle detect pulse
    p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/irq_ctrl_reg.sv
`timescale 1ns/1ps
module irq_ctrl_reg
    import irq_edge_pkg::*;
#(
    parameter int LEVEL_W = 3,
    parameter int CTRL_W  = LEVEL_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CTRL_W-1:0]  wr_data,
    output logic               en_q,
    output logic               en_next,
    output logic [LEVEL_W-1:0] level_q,
    output logic               clr_o
);
    localparam int CLR_BIT = LEVEL_W + 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            level_q <= '0;
        end else if (wr_en) begin
            en_q    <= wr_data[CR_EN_BIT];
            level_q <= wr_data[CR_LVL_LSB +: LEVEL_W];
        end
    end

    always_comb begin
        en_next = wr_en ? wr_data[CR_EN_BIT] : en_q;
        clr_o   = wr_en & wr_data[CLR_BIT];
    end

    // R8: register fields only move on a write
    p_reg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(en_q) && $stable(level_q)));

    // R8: a write lands its enable bit
    p_reg_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == $past(wr_data[CR_EN_BIT])));

endmodule

// File: rtl/irq_latch_fsm.sv
`timescale 1ns/1ps
module irq_latch_fsm
    import irq_edge_pkg::*;
#(
    parameter bit STRICT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic en_next_i,
    input  logic clr_i,
    output logic pending_o
);
    latch_state_e state_q, state_d;
    logic         capture_ok;

    localparam latch_state_e RESET_ST = STRICT ? LS_DISARMED : LS_ARMED;

    always_comb capture_ok = !STRICT || en_next_i;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RESET_ST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_DISARMED: begin
                if (capture_ok) state_d = edge_i ? LS_PENDING : LS_ARMED;
            end
            LS_ARMED: begin
                if (!capture_ok)  state_d = LS_DISARMED;
                else if (edge_i)  state_d = LS_PENDING;
            end
            LS_PENDING: begin
                if (!capture_ok)          state_d = LS_DISARMED;
                else if (clr_i && !edge_i) state_d = LS_ARMED;
            end
            default: state_d = RESET_ST;
        endcase
    end

    always_comb pending_o = (state_q == LS_PENDING);

    // R2: a detected edge is captured when capture is allowed
    p_edge_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && capture_ok) |=> pending_o);

    // R7: clear without a coincident edge empties the latch
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !edge_i) |=> !pending_o);

    // R4: the latch holds until cleared while capture is allowed
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !clr_i && capture_ok) |=> pending_o);

    // R5: strict variant drops the latch when disabled
    p_strict_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_ok |=> !pending_o);

endmodule

// File: rtl/irq_edge_ctrl.sv
`timescale 1ns/1ps
module irq_edge_ctrl
    import irq_edge_pkg::*;
#(
    parameter bit STRICT      = 1'b0,
    parameter int LEVEL_W     = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_i,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    output logic [LEVEL_W-1:0] irq_req
);
    localparam int CTRL_W  = LEVEL_W + 2;
    localparam int STS_BIT = LEVEL_W + 1;

    logic               edge_det;
    logic               en_q;
    logic               en_next;
    logic [LEVEL_W-1:0] level_q;
    logic               clr;
    logic               pending;
    logic               unused_hi_bits;

    always_comb unused_hi_bits = &{1'b0, wr_data[DATA_W-1:CTRL_W]};

    irq_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .edge_o (edge_det)
    );

    irq_ctrl_reg #(
        .LEVEL_W (LEVEL_W),
        .CTRL_W  (CTRL_W)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data[CTRL_W-1:0]),
        .en_q    (en_q),
        .en_next (en_next),
        .level_q (level_q),
        .clr_o   (clr)
    );

    irq_latch_fsm #(
        .STRICT (STRICT)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (edge_det),
        .en_next_i (en_next),
        .clr_i     (clr),
        .pending_o (pending)
    );

    always_comb begin
        irq_req = '0;
        if (pending && en_q && (level_q != '0)) irq_req = level_q;

        rd_data                             = '0;
        rd_data[CR_EN_BIT]                  = en_q;
        rd_data[CR_LVL_LSB +: LEVEL_W]      = level_q;
        rd_data[STS_BIT]                    = pending;
    end

    // R3: a request needs enable and a latched edge
    p_req_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req != '0) |-> (rd_data[CR_EN_BIT] && rd_data[STS_BIT]));

    // R6: level zero never produces a request
    p_level_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[CR_LVL_LSB +: LEVEL_W] == '0) |-> (irq_req == '0));

    // R5: strict variant shows no latched edge while disabled
    p_strict_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (STRICT && !rd_data[CR_EN_BIT]) |-> !rd_data[STS_BIT]);

endmodule

// File: tb/irq_edge_ctrl_tb.sv
`timescale 1ns/1ps
module irq_edge_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_i = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_l, rd_s;
    logic [2:0] req_l, req_s;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_edge_ctrl #(.STRICT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_l), .irq_req(req_l)
    );

    irq_edge_ctrl #(.STRICT(1'b1)) u_dut_strict (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_s), .irq_req(req_s)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        src_i = 1'b1;
        @(negedge clk);
        src_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [7:0] cr(input int en, input int lv, input int clr);
        return 8'((clr << 4) | (lv << 1) | en);
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 rd legacy", rd_l, 0);
        chk("R1 rd strict", rd_s, 0);
        chk("R1 req legacy", req_l, 0);
        chk("R1 req strict", req_s, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 rd after release", rd_l, 0);

        // Sweep: enable x level x latched (R3, R4, R5, R6, R8)
        for (int en = 0; en < 2; en++) begin
            for (int lv = 0; lv < 8; lv++) begin
                for (int p = 0; p < 2; p++) begin
                    int pl, ps, el, es;
                    wr(cr(1, lv, 1));
                    if (p == 1) pulse();
                    wr(cr(en, lv, 0));
                    pl = p;
                    ps = p & en;
                    el = (pl == 1 && en == 1 && lv != 0) ? lv : 0;
                    es = (ps == 1 && en == 1 && lv != 0) ? lv : 0;
                    chk($sformatf("R8 R4 rd legacy en%0d lv%0d p%0d", en, lv, p),
                        rd_l, (pl << 4) | (lv << 1) | en);
                    chk($sformatf("R8 R5 rd strict en%0d lv%0d p%0d", en, lv, p),
                        rd_s, (ps << 4) | (lv << 1) | en);
                    chk($sformatf("R3 R6 req legacy en%0d lv%0d p%0d", en, lv, p),
                        req_l, el);
                    chk($sformatf("R3 R6 req strict en%0d lv%0d p%0d", en, lv, p),
                        req_s, es);
                end
            end
        end

        // R2: latency of two synchronizer flops plus edge compare
        wr(cr(1, 2, 1));
        @(negedge clk); src_i = 1'b1;
        @(negedge clk); src_i = 1'b0;
        chk("R2 not yet after edge k", rd_l[4], 0);
        @(negedge clk);
        chk("R2 not yet after edge k+1", rd_l[4], 0);
        @(negedge clk);
        chk("R2 latched after edge k+2", rd_l[4], 1);
        chk("R2 req after edge k+2", req_l, 2);
        chk("R2 strict latched", rd_s[4], 1);

        // R2: a held-high line sets only once
        wr(cr(1, 2, 1));
        @(negedge clk); src_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 held line latched", rd_l[4], 1);
        wr(cr(1, 2, 1));
        repeat (5) @(negedge clk);
        chk("R2 held line no recapture legacy", rd_l[4], 0);
        chk("R2 held line no recapture strict", rd_s[4], 0);
        src_i = 1'b0;
        repeat (4) @(negedge clk);

        // R7: clear in the same cycle as a detected edge
        wr(cr(1, 3, 1));
        @(negedge clk); src_i = 1'b1;
        @(negedge clk); src_i = 1'b0;
        @(negedge clk); wr_en = 1'b1; wr_data = cr(1, 3, 1);
        @(negedge clk); wr_en = 1'b0;
        chk("R7 edge beats clear legacy", rd_l[4], 1);
        chk("R7 edge beats clear strict", rd_s[4], 1);
        chk("R7 req kept", req_l, 3);
        wr(cr(1, 3, 1));
        chk("R7 plain clear legacy", rd_l[4], 0);
        chk("R7 plain clear strict", rd_s[4], 0);
        chk("R7 req dropped", req_l, 0);

        // R4 / R5: edge while disabled, then enable
        wr(cr(0, 5, 1));
        pulse();
        chk("R4 disabled edge kept legacy", rd_l, 8'h1A);
        chk("R4 disabled req legacy", req_l, 0);
        chk("R5 disabled edge lost strict", rd_s, 8'h0A);
        wr(cr(1, 5, 0));
        chk("R4 enable raises req legacy", req_l, 5);
        chk("R5 enable no req strict", req_s, 0);
        chk("R5 strict still empty", rd_s[4], 0);

        // R6: level-zero mask keeps capturing, then unmask
        wr(cr(1, 0, 1));
        pulse();
        chk("R6 masked rd legacy", rd_l, 8'h11);
        chk("R6 masked rd strict", rd_s, 8'h11);
        chk("R6 masked req strict", req_s, 0);
        wr(cr(1, 3, 0));
        chk("R6 unmask req legacy", req_l, 3);
        chk("R6 unmask req strict", req_s, 3);

        // R1: reset in mid-operation
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset rd legacy", rd_l, 0);
        chk("R1 mid reset req strict", req_s, 0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule